// File: doc/BRIEF.md
# ADC channel scan sequencer

This block is the digital controller for a multichannel analog-to-digital converter. It walks a contiguous block of input channels, from a programmed first channel up to a programmed last channel. For each channel it drives the analog multiplexer select and holds a sample window whose length comes from a 3-bit timing code. It then issues a one-cycle convert request and waits for the converter's done handshake before it moves on.

Three scan behaviours are offered. A one-shot scan goes through the range once. A repeating scan wraps back to the first channel indefinitely. A stepped scan converts one channel per trigger and also wraps. The sample-and-hold, the comparator and the successive-approximation datapath sit outside the block and appear only as the `conv_done_i` input. Software writes the configuration through simple write strobes. The channel select register doubles as the first-channel readback.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block is idle with `busy_o`, `paused_o`, `sample_o`, `conv_req_o`, `scan_done_o` and `cfg_err_o` low, and `mux_sel_o`, `start_rd_o` and `end_rd_o` all zero.
- R2: With first channel below last channel, a trigger in idle converts each channel from first to last in ascending order, once each, and `mux_sel_o` does not change during a channel's sample window or convert request.
- R3: With first channel equal to last channel, a trigger converts exactly that one channel.
- R4: A trigger in idle with first channel above last channel starts no scan; `busy_o` stays low and `cfg_err_o` is high for exactly the one cycle after the trigger.
- R5: `sample_o` rises in the cycle after the channel is selected and stays high for N cycles, where the `stime_i` code 0..7 gives N = 4, 6, 8, 12, 24, 36, 48, 128.
- R6: `conv_req_o` is high for exactly one cycle, immediately after the last sample cycle. The block then waits for `conv_done_i`, and `conv_done_i` has no effect in any other state.
- R7: In repeating mode (`mode_i` = 01), after the last channel is converted the scan continues at the first channel without a trigger, until stopped.
- R8: In stepped mode (`mode_i` = 10), after each conversion the block holds with `paused_o` and `busy_o` high. The next trigger converts the following channel, which is the first channel after the last one.
- R9: In one-shot mode (`mode_i` = 00 or 11), `scan_done_o` pulses for one cycle in the cycle after `conv_done_i` for the last channel, when `busy_o` falls.
- R10: `start_rd_o` shows the channel most recently selected (zero after reset), not the written first-channel value, until a trigger starts a scan. From the next cycle it shows the new first channel.
- R11: While `busy_o` is high, writes to the last-channel field and to the mode and timing fields are ignored. In idle they take effect the next cycle.
- R12: `stop_i` in any state returns the block to idle in the next cycle, with `busy_o`, `sample_o` and `conv_req_o` low. A stop wins over a simultaneous trigger.
- R13: A trigger while a scan is sampling, converting or waiting for done has no effect on the channel order or the number of completed scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Write strobe for the first-channel field |
| start_ch_i | input | 4 | First channel write data |
| wr_end_i | input | 1 | Write strobe for the last-channel field |
| end_ch_i | input | 4 | Last channel write data |
| wr_ctrl_i | input | 1 | Write strobe for mode and timing fields |
| mode_i | input | 2 | 00 one-shot, 01 repeating, 10 stepped, 11 one-shot |
| stime_i | input | 3 | Sample window code |
| trig_i | input | 1 | Start a scan in idle, continue in stepped hold |
| stop_i | input | 1 | Abort to idle |
| conv_done_i | input | 1 | Conversion finished handshake |
| mux_sel_o | output | 4 | Analog multiplexer select |
| sample_o | output | 1 | Sample window enable |
| conv_req_o | output | 1 | One-cycle convert request |
| busy_o | output | 1 | Scan active or held |
| paused_o | output | 1 | Stepped-mode hold |
| scan_done_o | output | 1 | One-shot scan complete pulse |
| cfg_err_o | output | 1 | Pulse on trigger with first above last channel |
| start_rd_o | output | 4 | First-channel readback |
| end_rd_o | output | 4 | Last-channel readback |

## Verification
The hardest situation to reach from the ports is a configuration write that arrives while a scan is in flight. To get there, the bench uses the 128-cycle sample code so that the window stays open long enough. It issues the last-channel and mode writes mid-window and also fires extra triggers there. Spurious `conv_done_i` pulses are injected during sampling. The channel log and the readback then show that none of these changed the scan. The repeating-mode wrap is reached with the range at the top two channels, so that the wrap and the channel-field upper bound are exercised together.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned WIN_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV,
    ST_WAIT,
    ST_PAUSE
  } scan_state_e;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_STEP   = 2'b10,
    MODE_ONCE_B = 2'b11
  } scan_mode_e;

  // non-linear sample window table
  function automatic logic [WIN_W-1:0] win_cycles(input logic [2:0] code);
    case (code)
      3'd0:    win_cycles = 8'd4;
      3'd1:    win_cycles = 8'd6;
      3'd2:    win_cycles = 8'd8;
      3'd3:    win_cycles = 8'd12;
      3'd4:    win_cycles = 8'd24;
      3'd5:    win_cycles = 8'd36;
      3'd6:    win_cycles = 8'd48;
      default: win_cycles = 8'd128;
    endcase
  endfunction
endpackage

// File: rtl/adc_scan_cfg.sv
module adc_scan_cfg
  import adc_scan_pkg::*;
#(
  parameter int unsigned CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            busy_i,
  input  logic            wr_start_i,
  input  logic [CH_W-1:0] start_ch_i,
  input  logic            wr_end_i,
  input  logic [CH_W-1:0] end_ch_i,
  input  logic            wr_ctrl_i,
  input  logic [1:0]      mode_i,
  input  logic [2:0]      stime_i,
  output logic [CH_W-1:0] start_q_o,
  output logic [CH_W-1:0] end_q_o,
  output scan_mode_e      mode_q_o,
  output logic [2:0]      stime_q_o
);
  // first channel may be rewritten any time; it only takes effect at the next start or wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q_o <= '0;
    else if (wr_start_i) start_q_o <= start_ch_i;
  end

  // range end and timing are frozen while a scan owns them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) end_q_o <= '0;
    else if (wr_end_i && !busy_i) end_q_o <= end_ch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o  <= MODE_ONCE;
      stime_q_o <= '0;
    end else if (wr_ctrl_i && !busy_i) begin
      mode_q_o  <= scan_mode_e'(mode_i);
      stime_q_o <= stime_i;
    end
  end
endmodule

// File: rtl/adc_scan_timer.sv
module adc_scan_timer
  import adc_scan_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] code_i,
  output logic       last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'(win_cycles(code_i)) - CNT_W'(1);
  assign last_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else           cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int unsigned CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic            stop_i,
  input  logic            done_i,
  input  logic            win_last_i,
  input  logic [CH_W-1:0] start_ch_i,
  input  logic [CH_W-1:0] end_ch_i,
  input  scan_mode_e      mode_i,
  output scan_state_e     state_o,
  output logic [CH_W-1:0] ch_o,
  output logic            scan_done_o,
  output logic            cfg_err_o
);
  scan_state_e     st_q, st_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            done_d, err_d;
  logic            at_end;
  logic [CH_W-1:0] ch_next;

  assign at_end  = (ch_q == end_ch_i);
  assign ch_next = at_end ? start_ch_i : ch_q + CH_W'(1);

  always_comb begin
    st_d   = st_q;
    ch_d   = ch_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (stop_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (trig_i) begin
          if (start_ch_i > end_ch_i) err_d = 1'b1;
          else begin
            st_d = ST_SAMPLE;
            ch_d = start_ch_i;
          end
        end
        ST_SAMPLE: if (win_last_i) st_d = ST_CONV;
        ST_CONV:   st_d = ST_WAIT;
        ST_WAIT: if (done_i) begin
          if (mode_i == MODE_STEP) begin
            st_d = ST_PAUSE;
          end else if (!at_end || mode_i == MODE_REPEAT) begin
            st_d = ST_SAMPLE;
            ch_d = ch_next;
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        ST_PAUSE: if (trig_i) begin
          st_d = ST_SAMPLE;
          ch_d = ch_next;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ch_q        <= '0;
      scan_done_o <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else begin
      st_q        <= st_d;
      ch_q        <= ch_d;
      scan_done_o <= done_d;
      cfg_err_o   <= err_d;
    end
  end

  assign state_o = st_q;
  assign ch_o    = ch_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned CH_W  = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_start_i,
  input  logic [CH_W-1:0] start_ch_i,
  input  logic            wr_end_i,
  input  logic [CH_W-1:0] end_ch_i,
  input  logic            wr_ctrl_i,
  input  logic [1:0]      mode_i,
  input  logic [2:0]      stime_i,
  input  logic            trig_i,
  input  logic            stop_i,
  input  logic            conv_done_i,
  output logic [CH_W-1:0] mux_sel_o,
  output logic            sample_o,
  output logic            conv_req_o,
  output logic            busy_o,
  output logic            paused_o,
  output logic            scan_done_o,
  output logic            cfg_err_o,
  output logic [CH_W-1:0] start_rd_o,
  output logic [CH_W-1:0] end_rd_o
);
  logic [CH_W-1:0] start_q, end_q, ch_q;
  scan_mode_e      mode_q;
  logic [2:0]      stime_q;
  scan_state_e     st_q;
  logic            win_last;

  adc_scan_cfg #(.CH_W(CH_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy_o),
    .wr_start_i (wr_start_i),
    .start_ch_i (start_ch_i),
    .wr_end_i   (wr_end_i),
    .end_ch_i   (end_ch_i),
    .wr_ctrl_i  (wr_ctrl_i),
    .mode_i     (mode_i),
    .stime_i    (stime_i),
    .start_q_o  (start_q),
    .end_q_o    (end_q),
    .mode_q_o   (mode_q),
    .stime_q_o  (stime_q)
  );

  adc_scan_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == ST_SAMPLE),
    .code_i (stime_q),
    .last_o (win_last)
  );

  adc_scan_fsm #(.CH_W(CH_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .stop_i      (stop_i),
    .done_i      (conv_done_i),
    .win_last_i  (win_last),
    .start_ch_i  (start_q),
    .end_ch_i    (end_q),
    .mode_i      (mode_q),
    .state_o     (st_q),
    .ch_o        (ch_q),
    .scan_done_o (scan_done_o),
    .cfg_err_o   (cfg_err_o)
  );

  // all strobes decode straight from the state register
  assign sample_o   = (st_q == ST_SAMPLE);
  assign conv_req_o = (st_q == ST_CONV);
  assign busy_o     = (st_q != ST_IDLE);
  assign paused_o   = (st_q == ST_PAUSE);
  assign mux_sel_o  = ch_q;
  assign start_rd_o = ch_q;
  assign end_rd_o   = end_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
#(
  parameter int unsigned CH_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stop_i,
  input logic [CH_W-1:0] mux_sel_o,
  input logic            sample_o,
  input logic            conv_req_o,
  input logic            busy_o,
  input logic            paused_o,
  input logic            scan_done_o,
  input logic            cfg_err_o,
  input logic [CH_W-1:0] end_rd_o,
  input logic [2:0]      stime_q
);
  logic [WIN_W-1:0] samp_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) samp_run <= '0;
    else if (!sample_o) samp_run <= '0;
    else if (samp_run != {WIN_W{1'b1}}) samp_run <= samp_run + 1'b1;
  end

  assert_win_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> samp_run == win_cycles(stime_q));

  assert_conv_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);

  assert_conv_after_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> $past(sample_o));

  assert_mux_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o || (sample_o && $past(sample_o))) |-> $stable(mux_sel_o));

  assert_err_no_scan_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !busy_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |-> !busy_o && $past(busy_o));

  assert_pause_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> busy_o && !sample_o && !conv_req_o);

  assert_end_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> $stable(end_rd_o));

  assert_stop_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_o && !sample_o && !conv_req_o);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_i      (stop_i),
  .mux_sel_o   (mux_sel_o),
  .sample_o    (sample_o),
  .conv_req_o  (conv_req_o),
  .busy_o      (busy_o),
  .paused_o    (paused_o),
  .scan_done_o (scan_done_o),
  .cfg_err_o   (cfg_err_o),
  .end_rd_o    (end_rd_o),
  .stime_q     (stime_q)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_start = 0, wr_end = 0, wr_ctrl = 0;
  logic [3:0] start_ch = 0, end_ch = 0;
  logic [1:0] mode = 0;
  logic [2:0] stime = 0;
  logic       trig = 0, stop = 0, spur_done = 0, auto_done = 0;
  logic       conv_done;
  logic [3:0] mux_sel, start_rd, end_rd;
  logic       sample, conv_req, busy, paused, scan_done, cfg_err;

  assign conv_done = auto_done | spur_done;

  adc_scan_seq uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_start_i(wr_start), .start_ch_i(start_ch),
    .wr_end_i(wr_end), .end_ch_i(end_ch),
    .wr_ctrl_i(wr_ctrl), .mode_i(mode), .stime_i(stime),
    .trig_i(trig), .stop_i(stop), .conv_done_i(conv_done),
    .mux_sel_o(mux_sel), .sample_o(sample), .conv_req_o(conv_req),
    .busy_o(busy), .paused_o(paused), .scan_done_o(scan_done),
    .cfg_err_o(cfg_err), .start_rd_o(start_rd), .end_rd_o(end_rd)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int win_tab [8] = '{4, 6, 8, 12, 24, 36, 48, 128};

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 sampling, 2 convert, 3 awaiting done, 4 held
  int m_st, m_left, m_ch, m_start, m_end, m_mode, m_stime;
  bit m_done, m_err, m_was_busy;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_left = 0; m_ch = 0; m_start = 0; m_end = 0;
      m_mode = 0; m_stime = 0; m_done = 0; m_err = 0;
    end else begin
      m_was_busy = (m_st != 0);
      m_done = 0; m_err = 0;
      if (stop) m_st = 0;
      else if (m_st == 0) begin
        if (trig) begin
          if (m_start > m_end) m_err = 1;
          else begin m_st = 1; m_ch = m_start; m_left = win_tab[m_stime]; end
        end
      end else if (m_st == 1) begin
        m_left--;
        if (m_left == 0) m_st = 2;
      end else if (m_st == 2) m_st = 3;
      else if (m_st == 3) begin
        if (conv_done) begin
          if (m_mode == 2) m_st = 4;
          else if (m_ch != m_end) begin m_ch++; m_st = 1; m_left = win_tab[m_stime]; end
          else if (m_mode == 1) begin m_ch = m_start; m_st = 1; m_left = win_tab[m_stime]; end
          else begin m_st = 0; m_done = 1; end
        end
      end else if (m_st == 4 && trig) begin
        m_ch = (m_ch == m_end) ? m_start : m_ch + 1;
        m_st = 1; m_left = win_tab[m_stime];
      end
      if (wr_start) m_start = start_ch;
      if (wr_end && !m_was_busy) m_end = end_ch;
      if (wr_ctrl && !m_was_busy) begin m_mode = mode; m_stime = stime; end
    end
  end

  // compare against the reference every cycle
  always @(negedge clk) if (rst_ni) begin
    chk(mux_sel == m_ch,        "R2",  "mux_sel",   mux_sel, m_ch);
    chk(start_rd == m_ch,       "R10", "start_rd",  start_rd, m_ch);
    chk(sample == (m_st == 1),  "R5",  "sample",    sample, m_st == 1);
    chk(conv_req == (m_st == 2),"R6",  "conv_req",  conv_req, m_st == 2);
    chk(busy == (m_st != 0),    "R12", "busy",      busy, m_st != 0);
    chk(paused == (m_st == 4),  "R8",  "paused",    paused, m_st == 4);
    chk(scan_done == m_done,    "R9",  "scan_done", scan_done, m_done);
    chk(cfg_err == m_err,       "R4",  "cfg_err",   cfg_err, m_err);
    chk(end_rd == m_end,        "R11", "end_rd",    end_rd, m_end);
  end

  // converter stand-in, logs and window measurement
  int lat = 2, dcnt = 0, run = 0, last_run = 0, done_cnt = 0;
  int conv_log[$];
  always @(negedge clk) begin
    auto_done = 0;
    if (dcnt > 0) begin dcnt--; if (dcnt == 0) auto_done = 1; end
    if (conv_req) begin dcnt = lat; conv_log.push_back(int'(mux_sel)); end
    if (sample) run++;
    else if (run > 0) begin last_run = run; run = 0; end
    if (scan_done) done_cnt++;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog R12: actual %0d cycles expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic log_chk(input string req, input int exp[$]);
    checks++;
    if (conv_log != exp) begin
      errors++;
      $display("FAIL %s channel order: actual %p expected %p", req, conv_log, exp);
    end
  endtask

  task automatic cfg(input int s, input int e, input int md, input int st);
    @(negedge clk);
    wr_start = 1; wr_end = 1; wr_ctrl = 1;
    start_ch = 4'(s); end_ch = 4'(e); mode = 2'(md); stime = 3'(st);
    @(negedge clk);
    wr_start = 0; wr_end = 0; wr_ctrl = 0;
  endtask

  task automatic fire();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic halt();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wait_held();
    while (!paused) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !sample && !conv_req && !paused && !scan_done && !cfg_err, "R1", "strobes idle", busy, 0);
    chk(mux_sel == 0 && start_rd == 0 && end_rd == 0, "R1", "channel fields zero", mux_sel, 0);

    // R2 ascending one-shot scan, R9 completion pulse
    cfg(2, 5, 0, 0);
    conv_log.delete(); done_cnt = 0;
    fire(); wait_idle(); @(negedge clk);
    log_chk("R2", '{2, 3, 4, 5});
    chk(done_cnt == 1, "R9", "scan_done pulses", done_cnt, 1);

    // R10 readback keeps last channel until a new start
    @(negedge clk); wr_start = 1; start_ch = 9; wr_end = 1; end_ch = 9;
    @(negedge clk); wr_start = 0; wr_end = 0;
    @(negedge clk);
    chk(start_rd == 5, "R10", "readback before start", start_rd, 5);
    conv_log.delete();
    fire();
    chk(start_rd == 9, "R10", "readback after start", start_rd, 9);
    wait_idle(); @(negedge clk);
    log_chk("R3", '{9});

    // R5 every window code
    for (int k = 0; k < 8; k++) begin
      cfg(1, 1, 0, k);
      fire(); wait_idle(); @(negedge clk);
      chk(last_run == win_tab[k], "R5", "sample window length", last_run, win_tab[k]);
    end

    // R4 reversed range
    cfg(7, 3, 0, 0);
    fire();
    chk(cfg_err && !busy, "R4", "error pulse, no scan", cfg_err, 1);
    @(negedge clk);
    chk(!cfg_err && !busy, "R4", "error pulse ends", cfg_err, 0);

    // R7 repeating scan wraps at top of channel range
    cfg(14, 15, 1, 0);
    conv_log.delete(); lat = 1;
    fire();
    while (conv_log.size() < 5) @(negedge clk);
    halt();
    chk(!busy && !sample && !conv_req, "R12", "stopped after repeat", busy, 0);
    log_chk("R7", '{14, 15, 14, 15, 14});

    // R8 stepped scan
    cfg(3, 5, 2, 1);
    conv_log.delete(); lat = 3;
    fire(); wait_held();
    log_chk("R8", '{3});
    for (int i = 0; i < 3; i++) begin
      fire(); wait_held();
    end
    log_chk("R8", '{3, 4, 5, 3});
    chk(paused && busy, "R8", "held between channels", paused, 1);
    halt();

    // R11 protected writes during a long window, R13 stray triggers, R6 stray done
    cfg(0, 2, 0, 7);
    conv_log.delete(); done_cnt = 0;
    fire();
    repeat (5) @(negedge clk);
    wr_end = 1; end_ch = 10; wr_ctrl = 1; mode = 2'b01; stime = 3'd0;
    @(negedge clk); wr_end = 0; wr_ctrl = 0;
    trig = 1; spur_done = 1;
    @(negedge clk); trig = 0; spur_done = 0;
    repeat (10) @(negedge clk);
    trig = 1;
    @(negedge clk); trig = 0;
    wait_idle(); @(negedge clk);
    chk(end_rd == 2, "R11", "end field frozen in scan", end_rd, 2);
    log_chk("R13", '{0, 1, 2});
    chk(done_cnt == 1, "R13", "completed scans", done_cnt, 1);
    chk(last_run == 128, "R6", "window unaffected by stray done", last_run, 128);
    @(negedge clk); wr_end = 1; end_ch = 10;
    @(negedge clk); wr_end = 0;
    @(negedge clk);
    chk(end_rd == 10, "R11", "end field written in idle", end_rd, 10);

    // R12 stop mid-window, stop beats trigger
    cfg(4, 6, 0, 5);
    fire();
    repeat (3) @(negedge clk);
    stop = 1;
    @(negedge clk); stop = 0;
    chk(!sample && !busy && !conv_req, "R12", "stop during sample", sample, 0);
    @(negedge clk); stop = 1; trig = 1;
    @(negedge clk); stop = 0; trig = 0;
    chk(!busy, "R12", "stop wins over trigger", busy, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule